// File: doc/BRIEF.md
# Posted-Write Ordering Bridge with Master Grant Gating

This block keeps transfers in order where a host-side bus meets a slower expansion bus. Host writes bound for the expansion bus are posted into a small queue and acknowledged at once. A host read gets a single pending slot. It is issued to the expansion-bus target only after every write accepted before it has completed. Writes that arrive after the read are still accepted, so a stalled read never blocks write traffic. Each target cycle on the expansion bus is held until the target raises ready, and the target may insert any number of wait cycles first.

A local master on the expansion bus cannot be told to retry once its cycle has started. It could therefore deadlock against writes still sitting in the queue. To prevent this, the block grants the master only when the queue is empty, no target cycle is in progress and no read is pending. From the moment the master asks until its grant is released, every new host request toward the expansion bus is answered with retry. The grant falls one cycle after the master drops its request, and host traffic flows again from the next cycle.

Top module: `pw_order_bridge`

## Requirements
- R1: Posted writes reach the target (`t_valid`=1, `t_we`=1) in exactly the order the host saw them acknowledged. A target cycle keeps `t_valid`, `t_we` and `t_addr` steady until the cycle in which `t_ready` is 1, with any number of wait cycles before that.
- R2: The write queue holds 4 entries, with one more write in flight on the target port. A host write (`h_we`=1) that finds the queue full receives `h_retry` instead of `h_ack`.
- R3: A host read (`h_we`=0) is presented to the target (`t_we`=0) only after every write acknowledged before it has completed. Once those writes are done, the read goes ahead of writes acknowledged after it.
- R4: Host writes are acknowledged while a read is pending, as long as the queue has room and no master is requesting.
- R5: A completed target read produces `rc_valid` for one cycle, in the cycle after the `t_ready` handshake, with `rc_data` equal to the `t_rdata` sampled at that handshake. A second read while one is pending is answered with retry.
- R6: `m_gnt` rises only when the write queue is empty, the target port is idle and no read is pending.
- R7: While `m_req` or `m_gnt` is 1, every host request gets `h_retry` and none is acknowledged.
- R8: `m_gnt` falls at the first clock edge at which `m_req` is sampled 0. Host writes are acknowledged again from the following cycle.
- R9: No target cycle is started or in progress while `m_gnt` is 1.
- R10: After reset, `t_valid`, `m_gnt` and `rc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request present this cycle |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_ack | output | 1 | Request accepted this cycle |
| h_retry | output | 1 | Request refused; host must retry |
| t_valid | output | 1 | Target cycle in progress |
| t_we | output | 1 | Target cycle is a write |
| t_addr | output | AW | Target address |
| t_wdata | output | DW | Target write data |
| t_ready | input | 1 | Target completes the cycle |
| t_rdata | input | DW | Target read data, valid with t_ready |
| m_req | input | 1 | Expansion-bus master asks for the bus |
| m_gnt | output | 1 | Bus granted to the master |
| rc_valid | output | 1 | Read completion to host |
| rc_data | output | DW | Read completion data |

## Verification
Write bursts of one to five entries are swept against target wait counts of zero to three. After each burst a master request is raised, which shows whether the grant ever comes before the last queued write lands and whether requests made during the hold-off are refused. A long-wait burst fills the queue and separates correct capacity from an off-by-one full flag. A read placed between writes, with more writes behind it, tells apart reads that overtake earlier writes, reads that wait behind later writes, and reads that block new writes.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WR   = 2'd1,
    SEQ_RD   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pwq_fifo.sv
module pwq_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/pwq_target_seq.sv
module pwq_target_seq
  import pwq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_avail,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          hold,
  input  logic          t_ready,
  input  logic [DW-1:0] t_rdata,
  output logic          wr_pop,
  output logic          rd_issue,
  output logic          wr_done,
  output logic          idle,
  output logic          t_valid,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  output logic          rc_valid,
  output logic [DW-1:0] rc_data
);
  seq_state_t state;
  logic       rd_done;

  assign idle     = (state == SEQ_IDLE);
  assign rd_issue = idle && !hold && rd_go;
  assign wr_pop   = idle && !hold && !rd_go && wr_avail;
  assign wr_done  = (state == SEQ_WR) && t_ready;
  assign rd_done  = (state == SEQ_RD) && t_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      t_valid  <= 1'b0;
      t_we     <= 1'b0;
      t_addr   <= '0;
      t_wdata  <= '0;
      rc_valid <= 1'b0;
      rc_data  <= '0;
    end else begin
      rc_valid <= rd_done;
      if (rd_done) rc_data <= t_rdata;
      unique case (state)
        SEQ_IDLE: begin
          if (rd_issue) begin
            state   <= SEQ_RD;
            t_valid <= 1'b1;
            t_we    <= 1'b0;
            t_addr  <= rd_addr;
            t_wdata <= '0;
          end else if (wr_pop) begin
            state   <= SEQ_WR;
            t_valid <= 1'b1;
            t_we    <= 1'b1;
            t_addr  <= wr_addr;
            t_wdata <= wr_data;
          end
        end
        SEQ_WR, SEQ_RD: begin
          if (t_ready) begin
            state   <= SEQ_IDLE;
            t_valid <= 1'b0;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwq_grant.sv
module pwq_grant (
  input  logic clk,
  input  logic rst,
  input  logic m_req,
  input  logic quiet,
  output logic m_gnt
);
  always_ff @(posedge clk) begin
    if (rst) m_gnt <= 1'b0;
    else     m_gnt <= m_req && (m_gnt || quiet);
  end
endmodule

// File: rtl/pw_order_bridge.sv
module pw_order_bridge #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          h_ack,
  output logic          h_retry,
  output logic          t_valid,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  input  logic          t_ready,
  input  logic [DW-1:0] t_rdata,
  input  logic          m_req,
  output logic          m_gnt,
  output logic          rc_valid,
  output logic [DW-1:0] rc_data
);
  localparam int EW = AW + DW;
  localparam int OW = $clog2(DEPTH + 2);

  logic          fifo_full, fifo_empty, push, pop;
  logic [EW-1:0] head;
  logic          bus_busy, wr_ok, rd_ok, rd_accept;
  logic          rd_pend, rd_go, rd_issue, wr_done, seq_idle, quiet;
  logic [AW-1:0] rd_addr;
  logic [OW-1:0] out_cnt, ahead;

  assign bus_busy  = m_req || m_gnt;
  assign wr_ok     = !bus_busy && !fifo_full;
  assign rd_ok     = !bus_busy && !rd_pend;
  assign h_ack     = h_req && (h_we ? wr_ok : rd_ok);
  assign h_retry   = h_req && !h_ack;
  assign push      = h_ack && h_we;
  assign rd_accept = h_ack && !h_we;
  assign rd_go     = rd_pend && (ahead == '0);
  assign quiet     = fifo_empty && seq_idle && !rd_pend;

  pwq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din({h_addr, h_wdata}),
    .pop(pop), .dout(head), .full(fifo_full), .empty(fifo_empty)
  );

  pwq_target_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .wr_avail(!fifo_empty), .wr_addr(head[EW-1:DW]), .wr_data(head[DW-1:0]),
    .rd_go(rd_go), .rd_addr(rd_addr), .hold(m_gnt),
    .t_ready(t_ready), .t_rdata(t_rdata),
    .wr_pop(pop), .rd_issue(rd_issue), .wr_done(wr_done), .idle(seq_idle),
    .t_valid(t_valid), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
    .rc_valid(rc_valid), .rc_data(rc_data)
  );

  pwq_grant u_gnt (
    .clk(clk), .rst(rst), .m_req(m_req), .quiet(quiet), .m_gnt(m_gnt)
  );

  // writes acknowledged but not yet completed on the target port
  always_ff @(posedge clk) begin
    if (rst) out_cnt <= '0;
    else if (push && !wr_done) out_cnt <= out_cnt + OW'(1);
    else if (wr_done && !push) out_cnt <= out_cnt - OW'(1);
  end

  // single read slot; ahead counts the older writes it must wait for
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
      ahead   <= '0;
    end else if (rd_accept) begin
      rd_pend <= 1'b1;
      rd_addr <= h_addr;
      ahead   <= out_cnt - (wr_done ? OW'(1) : OW'(0));
    end else begin
      if (rd_issue) rd_pend <= 1'b0;
      if (wr_done && ahead != '0) ahead <= ahead - OW'(1);
    end
  end
endmodule

// File: rtl/pw_order_bridge_chk.sv
module pw_order_bridge_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          h_req,
  input logic          h_we,
  input logic          h_ack,
  input logic          h_retry,
  input logic          m_req,
  input logic          m_gnt,
  input logic          t_valid,
  input logic          t_ready,
  input logic          t_we,
  input logic [AW-1:0] t_addr,
  input logic          rc_valid,
  input logic          fifo_full,
  input logic          fifo_empty
);
  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (t_valid && !t_ready) |=> (t_valid && $stable(t_addr) && $stable(t_we))); // R1
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    (h_ack && h_we) |-> !fifo_full); // R2
  AST_RC_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rc_valid |-> $past(t_valid && t_ready && !t_we)); // R5
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(m_gnt) |-> $past(fifo_empty && !t_valid)); // R6
  AST_MASTER_RETRY: assert property (@(posedge clk) disable iff (rst)
    (h_req && (m_req || m_gnt)) |-> (h_retry && !h_ack)); // R7
  AST_GNT_DROP: assert property (@(posedge clk) disable iff (rst)
    !m_req |=> !m_gnt); // R8
  AST_GNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    m_gnt |-> !t_valid); // R9
endmodule

bind pw_order_bridge pw_order_bridge_chk #(.AW(AW)) u_chk (.*);

// File: tb/pw_order_bridge_bench.sv
module pw_order_bridge_bench;
  localparam logic [31:0] MAGIC = 32'hA5A5_3C3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [31:0] h_addr = '0, h_wdata = '0;
  logic        h_ack, h_retry;
  logic        t_valid, t_we;
  logic [31:0] t_addr, t_wdata;
  logic        t_ready = 1'b0;
  logic [31:0] t_rdata = '0;
  logic        m_req = 1'b0, m_gnt;
  logic        rc_valid;
  logic [31:0] rc_data;

  pw_order_bridge u_pw_order_bridge (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int tgt_wait = 0, wcnt = 0;
  int exp_n = 0, log_n = 0, rd_snap = 0, rc_n = 0;
  logic [31:0] exp_addr [256], exp_data [256], log_addr [256], log_data [256];
  logic [31:0] rd_exp = '0;
  logic        prev_g = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model, grant monitor, completion monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (t_ready) begin
        t_ready = 1'b0;
        wcnt = 0;
      end else if (t_valid) begin
        if (wcnt >= tgt_wait) begin
          t_ready = 1'b1;
          if (t_we) begin
            log_addr[log_n] = t_addr;
            log_data[log_n] = t_wdata;
            log_n++;
          end else begin
            t_rdata = t_addr ^ MAGIC;
            chk(log_n == rd_snap, "R3 read after exactly the older writes", log_n, rd_snap);
          end
        end else wcnt++;
      end
      if (m_gnt && !prev_g)
        chk(log_n == exp_n && !t_valid, "R6 grant only after drain", log_n, exp_n);
      if (m_gnt) chk(!t_valid, "R9 target idle under grant", t_valid, 0);
      if (rc_valid) begin
        chk(rc_data == rd_exp, "R5 completion data", rc_data, rd_exp);
        rc_n++;
      end
      prev_g = m_gnt;
    end
  end

  task automatic host_op(input bit we, input logic [31:0] a, input logic [31:0] d, output bit acked);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_wdata = d;
    #1;
    acked = h_ack;
    if (h_ack && we) begin
      exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    end
    if (h_ack && !we) begin
      rd_snap = exp_n; rd_exp = a ^ MAGIC;
    end
    @(posedge clk);
    #1 h_req = 1'b0;
  endtask

  task automatic host_wr_until(input logic [31:0] a, input logic [31:0] d);
    bit ok = 1'b0;
    for (int k = 0; k < 200 && !ok; k++) host_op(1'b1, a, d, ok);
    chk(ok, "R1 write eventually accepted", ok, 1);
  endtask

  task automatic drain();
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      #2;
      if (log_n == exp_n && !t_valid) break;
    end
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(!t_valid && !m_gnt && !rc_valid, "R10 reset state", {t_valid, m_gnt, rc_valid}, 0);

    // queue capacity: slow target, six writes back to back
    tgt_wait = 30;
    for (int i = 0; i < 6; i++) begin
      host_op(1'b1, 32'h100 + 32'(i) * 4, 32'hD000 + 32'(i), ok);
      chk(ok == (i < 5), "R2 queue capacity", ok, (i < 5));
    end
    drain();

    // sweep: burst length x target waits, then master request
    for (int w = 0; w < 4; w++) begin
      for (int n = 1; n <= 5; n++) begin
        tgt_wait = w;
        for (int i = 0; i < n; i++)
          host_wr_until(32'h2000 + 32'(w * 64 + n * 8 + i) * 4, 32'(w) * 32'h0101_0101 ^ 32'(n * 16 + i));
        @(negedge clk); m_req = 1'b1;
        host_op(1'b1, 32'hBAD0, 32'hBAD0, ok);
        chk(!ok, "R7 write retried while master requests", ok, 0);
        for (int k = 0; k < 500 && !m_gnt; k++) @(negedge clk);
        #1;
        chk(m_gnt, "R6 grant arrives after drain", m_gnt, 1);
        host_op(1'b0, 32'hBAD4, 0, ok);
        chk(!ok, "R7 read retried under grant", ok, 0);
        @(negedge clk); m_req = 1'b0; #1;
        chk(m_gnt, "R8 grant held until next edge", m_gnt, 1);
        @(negedge clk); #1;
        chk(!m_gnt, "R8 grant dropped one cycle after release", m_gnt, 0);
        host_op(1'b1, 32'h3000 + 32'(w * 8 + n), 32'hE000 + 32'(w * 8 + n), ok);
        chk(ok, "R8 writes resume after release", ok, 1);
        drain();
      end
    end

    // read between writes
    tgt_wait = 2;
    for (int i = 0; i < 3; i++) host_wr_until(32'h4000 + 32'(i) * 4, 32'hF000 + 32'(i));
    host_op(1'b0, 32'h4800, 0, ok);
    chk(ok, "R3 read accepted", ok, 1);
    host_op(1'b0, 32'h4804, 0, ok);
    chk(!ok, "R5 second read retried while one pending", ok, 0);
    for (int i = 0; i < 2; i++) begin
      host_op(1'b1, 32'h4100 + 32'(i) * 4, 32'hF100 + 32'(i), ok);
      chk(ok, "R4 write passes pending read", ok, 1);
    end
    drain();
    repeat (3) @(negedge clk);
    chk(rc_n == 1, "R5 one completion", rc_n, 1);

    // read refused while master requests an idle bus
    @(negedge clk); m_req = 1'b1;
    host_op(1'b0, 32'h5000, 0, ok);
    chk(!ok, "R7 read retried while master requests", ok, 0);
    @(negedge clk); m_req = 1'b0;
    repeat (3) @(negedge clk);

    chk(log_n == exp_n, "R1 write count delivered", log_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(log_addr[i] == exp_addr[i] && log_data[i] == exp_data[i],
          "R1 write order", log_addr[i], exp_addr[i]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule